// File: doc/BRIEF.md
# Audio Codec Extended Control Register Bank

This block is the bank of 8-bit control registers that sets the sample rates, wavetable muting and playback routing of an audio codec. Software reaches every register through two ports. It first writes an index byte that selects a register in one of two spaces, the main space or the extended space. It then writes or reads that register through a data port. The stored values go straight to the codec datapath as decoded control bits and volume bytes.

Two register locations need more than plain storage. Both wavetable mute bits take their reset value from an external configuration strap, and each is the inverse of that strap. The 3D-enable bit has one flop but two addresses, so a write through either address changes it. A remap bit in the routing register also changes how the volume indexes behave. While it is set, a write to a secondary-DAC volume index writes the matching AUX1 volume register at the same time.

Top module: `codec_xctl_regs`

## Requirements
- R1: A one-cycle pulse on `idx_we` loads the index. `wdata[4:0]` is the register index and `wdata[5]` selects the space (1 = extended, 0 = main). Later pulses on `data_we` write the selected register, and `rdata` shows its value combinationally. An index the bank does not implement reads 0x00, and writes to it change no register or output.
- R2: Extended index 0x12 holds the ADC rate code and drives `adc_rate`. Extended index 0x13 holds the DAC rate code and drives `dac_rate`. Both are full bytes that reset to 0x00.
- R3: Extended indexes 0x14 and 0x15 store a full byte and read it back. Writing them changes no output.
- R4: Bit 7 of extended index 0x16 drives `wt_mute_l`, and bit 7 of extended index 0x17 drives `wt_mute_r`. Bits 6..0 of both are stored, read back, and reset to 0.
- R5: While `rst_n` is low, each wavetable mute bit loads the inverse of `wt_strap`.
- R6: Extended index 0x18 is the routing register, reset to 0x00. Bit 7 drives `port_a_en`. Bit 6 is stored only. Bit 5 drives `aux1_remap`, bit 4 `en_3d`, bit 3 `dsp_to_dac1`, bit 2 `play_hold`, bit 1 `alt_port_en` and bit 0 `dig_loop`.
- R7: Main index 0x1B bit 0 and extended 0x18 bit 4 share one flop. A write through either address updates `en_3d` and both read-back views. Bits 7..1 of main 0x1B are stored only and reset to 0.
- R8: With `aux1_remap` set, a write to main index 18 (0x12) loads both `dac2_vol_l` and `aux1_vol_l`. A write to main index 19 (0x13) loads both `dac2_vol_r` and `aux1_vol_r`.
- R9: With `aux1_remap` clear, main indexes 18 and 19 write only the DAC2 volumes. In either mode, main index 2 writes `aux1_vol_l` and main index 3 writes `aux1_vol_r`. All four volumes reset to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wt_strap | input | 1 | Wavetable-enable configuration strap |
| idx_we | input | 1 | Index write strobe |
| data_we | input | 1 | Data write strobe |
| wdata | input | 8 | Write byte for the index or data port |
| rdata | output | 8 | Read value of the selected register |
| adc_rate | output | 8 | ADC sample-rate code |
| dac_rate | output | 8 | DAC sample-rate code |
| wt_mute_l | output | 1 | Left wavetable input mute |
| wt_mute_r | output | 1 | Right wavetable input mute |
| port_a_en | output | 1 | Port-A enable |
| aux1_remap | output | 1 | AUX1 volume remap enable |
| en_3d | output | 1 | 3D sound enable |
| dsp_to_dac1 | output | 1 | DSP port drives DAC1 |
| play_hold | output | 1 | Hold last sample on playback stop |
| alt_port_en | output | 1 | Alternate port drives DAC2 |
| dig_loop | output | 1 | ADC-to-DAC1 loopback |
| aux1_vol_l | output | 8 | AUX1 left volume |
| aux1_vol_r | output | 8 | AUX1 right volume |
| dac2_vol_l | output | 8 | DAC2 left volume |
| dac2_vol_r | output | 8 | DAC2 right volume |

## Verification
Every flop drives an output or the read mux, so a wrong stored value shows at the ports one cycle after the write strobe that caused it. It appears either on a decoded control pin or on `rdata` once the index selects that register. A bad alias on the 3D bit shows when one address is written and the other is read back. A bad remap decision shows on the AUX1 volume pins in the cycle after the write to main index 18 or 19. A bad strap decode shows on the mute pins in the first cycle after reset is released.

// File: rtl/codec_xctl_pkg.sv
// Package: shared index constants and bit positions for the extended
// control register bank. Assumes 8-bit registers and 5-bit indexes.
package codec_xctl_pkg;
    localparam int XCNT = 7;                       // extended registers 0x12..0x18
    localparam logic [4:0] X_BASE    = 5'h12;
    localparam logic [4:0] X_ADC     = 5'h12;
    localparam logic [4:0] X_DAC     = 5'h13;
    localparam logic [4:0] X_RSV_A   = 5'h14;
    localparam logic [4:0] X_RSV_B   = 5'h15;
    localparam logic [4:0] X_WT_L    = 5'h16;
    localparam logic [4:0] X_WT_R    = 5'h17;
    localparam logic [4:0] X_ROUTE   = 5'h18;
    // offsets into the extended array
    localparam int XO_ADC   = 0;
    localparam int XO_DAC   = 1;
    localparam int XO_RSV_A = 2;
    localparam int XO_RSV_B = 3;
    localparam int XO_WT_L  = 4;
    localparam int XO_WT_R  = 5;
    localparam int XO_ROUTE = 6;
    // main-space indexes held here
    localparam logic [4:0] M_AUX1_L  = 5'd2;
    localparam logic [4:0] M_AUX1_R  = 5'd3;
    localparam logic [4:0] M_DAC2_L  = 5'd18;
    localparam logic [4:0] M_DAC2_R  = 5'd19;
    localparam logic [4:0] M_CFG3D   = 5'h1B;
    localparam int MCNT = 5;
    localparam int MW_AUX1_L = 0;
    localparam int MW_AUX1_R = 1;
    localparam int MW_DAC2_L = 2;
    localparam int MW_DAC2_R = 3;
    localparam int MW_CFG3D  = 4;
    // routing register bit positions
    localparam int RB_PORTA = 7;
    localparam int RB_RSV   = 6;
    localparam int RB_REMAP = 5;
    localparam int RB_3D    = 4;
    localparam int RB_DSP   = 3;
    localparam int RB_HOLD  = 2;
    localparam int RB_ALT   = 1;
    localparam int RB_LOOP  = 0;
    localparam int WT_MUTE_BIT = 7;
    localparam int CFG_3D_BIT  = 0;
endpackage

// File: rtl/codec_xctl_dec.sv
// Index decoder: holds the space flag and index written via the index
// port and turns data-port strobes into per-register write enables.
// Assumes at most one strobe per cycle is meaningful; idx_we wins.
module codec_xctl_dec
    import codec_xctl_pkg::*;
#(
    parameter int IW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            idx_we,
    input  logic            data_we,
    input  logic [IW:0]     idx_in,
    output logic            cur_ext,
    output logic [IW-1:0]   cur_idx,
    output logic [XCNT-1:0] x_we,
    output logic [MCNT-1:0] m_we
);
    // Purpose: capture index and space flag on an index write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_ext <= 1'b0;
            cur_idx <= '0;
        end else if (idx_we) begin
            cur_ext <= idx_in[IW];
            cur_idx <= idx_in[IW-1:0];
        end
    end

    logic dwr;
    assign dwr = data_we && !idx_we;

    // Purpose: one write enable per extended register.
    for (genvar i = 0; i < XCNT; i++) begin : g_xwe
        assign x_we[i] = dwr && cur_ext && (cur_idx == X_BASE + IW'(i));
    end

    // Purpose: write enables for the main-space registers held here.
    always_comb begin
        m_we = '0;
        if (dwr && !cur_ext) begin
            m_we[MW_AUX1_L] = (cur_idx == M_AUX1_L);
            m_we[MW_AUX1_R] = (cur_idx == M_AUX1_R);
            m_we[MW_DAC2_L] = (cur_idx == M_DAC2_L);
            m_we[MW_DAC2_R] = (cur_idx == M_DAC2_R);
            m_we[MW_CFG3D]  = (cur_idx == M_CFG3D);
        end
    end

    AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({x_we, m_we})); // R1
    AST_IDX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        idx_we |=> (cur_idx == $past(idx_in[IW-1:0]))); // R1
endmodule

// File: rtl/codec_xctl_xbank.sv
// Extended register storage plus the aliased main config location.
// Mute bits reset to the inverse of the strap; the 3D bit is one flop
// reachable from two addresses. Assumes one write enable per cycle.
module codec_xctl_xbank
    import codec_xctl_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wt_strap,
    input  logic [XCNT-1:0]   x_we,
    input  logic              cfg_we,
    input  logic [DW-1:0]     wdata,
    output logic [XCNT*DW-1:0] x_flat,
    output logic [DW-1:0]     cfg_rd
);
    logic          en3d_q;
    logic [DW-2:0] cfg_hi_q;
    logic [DW-1:0] xr [XCNT];

    for (genvar i = 0; i < XCNT; i++) begin : g_x
        if (i == XO_ROUTE) begin : g_route
            logic [DW-2:0] rt_q;
            // Purpose: routing bits other than the shared 3D flop.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    rt_q <= '0;
                else if (x_we[i])
                    rt_q <= {wdata[DW-1:RB_3D+1], wdata[RB_3D-1:0]};
            end
            assign xr[i] = {rt_q[DW-2:RB_3D], en3d_q, rt_q[RB_3D-1:0]};
        end else if (i == XO_WT_L || i == XO_WT_R) begin : g_wt
            logic [DW-1:0] wt_q;
            // Purpose: mute byte whose top bit resets from the strap.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    wt_q <= {!wt_strap, {(DW-1){1'b0}}};
                else if (x_we[i])
                    wt_q <= wdata;
            end
            assign xr[i] = wt_q;
        end else begin : g_plain
            logic [DW-1:0] pl_q;
            // Purpose: plain byte register (rates and reserved bytes).
            always_ff @(posedge clk) begin
                if (!rst_n)
                    pl_q <= '0;
                else if (x_we[i])
                    pl_q <= wdata;
            end
            assign xr[i] = pl_q;
        end
        assign x_flat[i*DW +: DW] = xr[i];
    end

    // Purpose: shared 3D-enable flop written from either address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en3d_q <= 1'b0;
        else if (x_we[XO_ROUTE])
            en3d_q <= wdata[RB_3D];
        else if (cfg_we)
            en3d_q <= wdata[CFG_3D_BIT];
    end

    // Purpose: remaining bits of the main config byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_hi_q <= '0;
        else if (cfg_we)
            cfg_hi_q <= wdata[DW-1:1];
    end

    assign cfg_rd = {cfg_hi_q, en3d_q};

    AST_STRAP_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (xr[XO_WT_L][WT_MUTE_BIT] == !$past(wt_strap)
                          && xr[XO_WT_R][WT_MUTE_BIT] == !$past(wt_strap))); // R5
    AST_ALIAS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (xr[XO_ROUTE][RB_3D] == $past(wdata[CFG_3D_BIT]))); // R7
    AST_ALIAS_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        x_we[XO_ROUTE] |=> (cfg_rd[CFG_3D_BIT] == $past(wdata[RB_3D]))); // R7
    AST_RSV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (x_we[XO_RSV_A] || x_we[XO_RSV_B]) |=>
            ($stable(xr[XO_ADC]) && $stable(xr[XO_DAC]) && $stable(xr[XO_ROUTE])
             && $stable(xr[XO_WT_L]) && $stable(xr[XO_WT_R]))); // R3
    AST_RATE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        x_we[XO_ADC] |=> (xr[XO_ADC] == $past(wdata))); // R2
endmodule

// File: rtl/codec_xctl_vol.sv
// Volume registers for AUX1 and DAC2. When remap is set, a DAC2
// volume write also lands in the matching AUX1 register. Assumes the
// remap value seen is the one held before the current write.
module codec_xctl_vol
    import codec_xctl_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [MCNT-1:0] m_we,
    input  logic            remap,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   aux1_l,
    output logic [DW-1:0]   aux1_r,
    output logic [DW-1:0]   dac2_l,
    output logic [DW-1:0]   dac2_r
);
    logic ld_aux_l, ld_aux_r;
    assign ld_aux_l = m_we[MW_AUX1_L] || (remap && m_we[MW_DAC2_L]);
    assign ld_aux_r = m_we[MW_AUX1_R] || (remap && m_we[MW_DAC2_R]);

    // Purpose: AUX1 volume pair, direct or mirrored from DAC2 writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aux1_l <= '0;
            aux1_r <= '0;
        end else begin
            if (ld_aux_l) aux1_l <= wdata;
            if (ld_aux_r) aux1_r <= wdata;
        end
    end

    // Purpose: DAC2 volume pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac2_l <= '0;
            dac2_r <= '0;
        end else begin
            if (m_we[MW_DAC2_L]) dac2_l <= wdata;
            if (m_we[MW_DAC2_R]) dac2_r <= wdata;
        end
    end

    AST_REMAP_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (remap && m_we[MW_DAC2_L]) |=> (aux1_l == dac2_l)); // R8
    AST_NOREMAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!remap && m_we[MW_DAC2_R] && !m_we[MW_AUX1_R]) |=> $stable(aux1_r)); // R9
    AST_DAC2_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (m_we[MW_AUX1_L]) |=> $stable(dac2_l)); // R9
endmodule

// File: rtl/codec_xctl_regs.sv
// Top: extended control register bank of an audio codec. Index port,
// data port and combinational read mux; decoded controls to the datapath.
// Assumes a synchronous single-cycle bus strobe in the clk domain.
module codec_xctl_regs
    import codec_xctl_pkg::*;
#(
    parameter int DW = 8,
    parameter int IW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wt_strap,
    input  logic          idx_we,
    input  logic          data_we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] adc_rate,
    output logic [DW-1:0] dac_rate,
    output logic          wt_mute_l,
    output logic          wt_mute_r,
    output logic          port_a_en,
    output logic          aux1_remap,
    output logic          en_3d,
    output logic          dsp_to_dac1,
    output logic          play_hold,
    output logic          alt_port_en,
    output logic          dig_loop,
    output logic [DW-1:0] aux1_vol_l,
    output logic [DW-1:0] aux1_vol_r,
    output logic [DW-1:0] dac2_vol_l,
    output logic [DW-1:0] dac2_vol_r
);
    logic               cur_ext;
    logic [IW-1:0]      cur_idx;
    logic [XCNT-1:0]    x_we;
    logic [MCNT-1:0]    m_we;
    logic [XCNT*DW-1:0] x_flat;
    logic [DW-1:0]      cfg_rd;
    logic [DW-1:0]      route;

    codec_xctl_dec #(.IW(IW)) u_dec (
        .clk(clk), .rst_n(rst_n), .idx_we(idx_we), .data_we(data_we),
        .idx_in(wdata[IW:0]), .cur_ext(cur_ext), .cur_idx(cur_idx),
        .x_we(x_we), .m_we(m_we)
    );

    codec_xctl_xbank #(.DW(DW)) u_xbank (
        .clk(clk), .rst_n(rst_n), .wt_strap(wt_strap), .x_we(x_we),
        .cfg_we(m_we[MW_CFG3D]), .wdata(wdata), .x_flat(x_flat), .cfg_rd(cfg_rd)
    );

    codec_xctl_vol #(.DW(DW)) u_vol (
        .clk(clk), .rst_n(rst_n), .m_we(m_we), .remap(aux1_remap), .wdata(wdata),
        .aux1_l(aux1_vol_l), .aux1_r(aux1_vol_r),
        .dac2_l(dac2_vol_l), .dac2_r(dac2_vol_r)
    );

    assign route       = x_flat[XO_ROUTE*DW +: DW];
    assign adc_rate    = x_flat[XO_ADC*DW +: DW];
    assign dac_rate    = x_flat[XO_DAC*DW +: DW];
    assign wt_mute_l   = x_flat[XO_WT_L*DW + WT_MUTE_BIT];
    assign wt_mute_r   = x_flat[XO_WT_R*DW + WT_MUTE_BIT];
    assign port_a_en   = route[RB_PORTA];
    assign aux1_remap  = route[RB_REMAP];
    assign en_3d       = route[RB_3D];
    assign dsp_to_dac1 = route[RB_DSP];
    assign play_hold   = route[RB_HOLD];
    assign alt_port_en = route[RB_ALT];
    assign dig_loop    = route[RB_LOOP];

    // Purpose: combinational read of the register the index selects.
    always_comb begin
        rdata = '0;
        if (cur_ext) begin
            for (int i = 0; i < XCNT; i++)
                if (cur_idx == X_BASE + IW'(i))
                    rdata = x_flat[i*DW +: DW];
        end else begin
            unique case (cur_idx)
                M_AUX1_L: rdata = aux1_vol_l;
                M_AUX1_R: rdata = aux1_vol_r;
                M_DAC2_L: rdata = dac2_vol_l;
                M_DAC2_R: rdata = dac2_vol_r;
                M_CFG3D:  rdata = cfg_rd;
                default:  rdata = '0;
            endcase
        end
    end

    AST_ROUTE_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (route == '0)); // R6
    AST_DAC_RATE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && !idx_we && cur_ext && cur_idx == X_DAC) |=> (dac_rate == $past(wdata))); // R2
endmodule

// File: tb/codec_xctl_regs_bench.sv
module codec_xctl_regs_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wt_strap = 1'b1;
    logic       idx_we = 1'b0;
    logic       data_we = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata, adc_rate, dac_rate;
    logic       wt_mute_l, wt_mute_r, port_a_en, aux1_remap, en_3d;
    logic       dsp_to_dac1, play_hold, alt_port_en, dig_loop;
    logic [7:0] aux1_vol_l, aux1_vol_r, dac2_vol_l, dac2_vol_r;

    always #10 clk = ~clk;

    codec_xctl_regs u_codec_xctl_regs (
        .clk(clk), .rst_n(rst_n), .wt_strap(wt_strap), .idx_we(idx_we),
        .data_we(data_we), .wdata(wdata), .rdata(rdata), .adc_rate(adc_rate),
        .dac_rate(dac_rate), .wt_mute_l(wt_mute_l), .wt_mute_r(wt_mute_r),
        .port_a_en(port_a_en), .aux1_remap(aux1_remap), .en_3d(en_3d),
        .dsp_to_dac1(dsp_to_dac1), .play_hold(play_hold), .alt_port_en(alt_port_en),
        .dig_loop(dig_loop), .aux1_vol_l(aux1_vol_l), .aux1_vol_r(aux1_vol_r),
        .dac2_vol_l(dac2_vol_l), .dac2_vol_r(dac2_vol_r)
    );

    typedef struct {
        string      req;
        int         sel;
        logic [7:0] exp;
    } item_t;

    item_t sb[$];
    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 0;

    // observed value per selector: 0 rdata, 1 adc, 2 dac, 3 mutes,
    // 4 routing outputs (bit 6 forced 0), 5..8 volumes
    function automatic logic [7:0] obs(int sel);
        case (sel)
            0: return rdata;
            1: return adc_rate;
            2: return dac_rate;
            3: return {6'b0, wt_mute_l, wt_mute_r};
            4: return {port_a_en, 1'b0, aux1_remap, en_3d, dsp_to_dac1,
                       play_hold, alt_port_en, dig_loop};
            5: return aux1_vol_l;
            6: return aux1_vol_r;
            7: return dac2_vol_l;
            default: return dac2_vol_r;
        endcase
    endfunction

    // monitor: pops expectations and compares away from the clock edge
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [7:0] got;
            it = sb.pop_front();
            got = obs(it.sel);
            n_chk++;
            if (got !== it.exp) begin
                n_bad++;
                $display("FAIL %s sel=%0d actual=%02h expected=%02h", it.req, it.sel, got, it.exp);
            end
        end
    end

    task automatic put_idx(bit ext, logic [4:0] i);
        @(posedge clk); #1;
        idx_we = 1'b1; wdata = {2'b00, ext, i};
        @(posedge clk); #1;
        idx_we = 1'b0;
    endtask

    task automatic put_dat(logic [7:0] v);
        @(posedge clk); #1;
        data_we = 1'b1; wdata = v;
        @(posedge clk); #1;
        data_we = 1'b0;
    endtask

    task automatic wr(bit ext, logic [4:0] i, logic [7:0] v);
        put_idx(ext, i);
        put_dat(v);
    endtask

    // driver: push an expectation, let the monitor consume it
    task automatic expect_val(string req, int sel, logic [7:0] e);
        item_t it;
        it.req = req; it.sel = sel; it.exp = e;
        sb.push_back(it);
        @(posedge clk); #1;
    endtask

    task automatic rd(string req, bit ext, logic [4:0] i, logic [7:0] e);
        put_idx(ext, i);
        expect_val(req, 0, e);
    endtask

    task automatic do_reset(bit strap);
        @(posedge clk); #1;
        wt_strap = strap; rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    initial begin
        do_reset(1'b1);
        // reset state
        expect_val("R5", 3, 8'h00);
        rd("R4", 1'b1, 5'h16, 8'h00);
        rd("R6", 1'b1, 5'h18, 8'h00);
        expect_val("R6", 4, 8'h00);
        rd("R2", 1'b1, 5'h12, 8'h00);
        expect_val("R9", 5, 8'h00);
        // rate bytes
        wr(1'b1, 5'h12, 8'hA5);
        expect_val("R2", 1, 8'hA5);
        expect_val("R2", 0, 8'hA5);
        wr(1'b1, 5'h13, 8'h3C);
        expect_val("R2", 2, 8'h3C);
        // reserved bytes
        wr(1'b1, 5'h14, 8'h5A);
        expect_val("R3", 0, 8'h5A);
        expect_val("R3", 1, 8'hA5);
        expect_val("R3", 4, 8'h00);
        wr(1'b1, 5'h15, 8'hFF);
        expect_val("R3", 0, 8'hFF);
        expect_val("R3", 3, 8'h00);
        expect_val("R3", 2, 8'h3C);
        // mutes
        wr(1'b1, 5'h16, 8'hC3);
        expect_val("R4", 3, 8'h02);
        expect_val("R4", 0, 8'hC3);
        wr(1'b1, 5'h17, 8'h01);
        expect_val("R4", 3, 8'h02);
        expect_val("R4", 0, 8'h01);
        wr(1'b1, 5'h17, 8'h80);
        expect_val("R4", 3, 8'h03);
        // routing register
        wr(1'b1, 5'h18, 8'hFF);
        expect_val("R6", 0, 8'hFF);
        expect_val("R6", 4, 8'hBF);
        wr(1'b1, 5'h18, 8'h0A);
        expect_val("R6", 4, 8'h0A);
        wr(1'b1, 5'h18, 8'h10);
        expect_val("R6", 4, 8'h10);
        // 3D alias
        wr(1'b0, 5'h1B, 8'h00);
        expect_val("R7", 4, 8'h00);
        rd("R7", 1'b1, 5'h18, 8'h00);
        wr(1'b0, 5'h1B, 8'hA7);
        expect_val("R7", 0, 8'hA7);
        expect_val("R7", 4, 8'h10);
        rd("R7", 1'b1, 5'h18, 8'h10);
        wr(1'b1, 5'h18, 8'h00);
        rd("R7", 1'b0, 5'h1B, 8'hA6);
        // remap clear
        wr(1'b0, 5'd18, 8'h11);
        expect_val("R9", 7, 8'h11);
        expect_val("R9", 5, 8'h00);
        wr(1'b0, 5'd2, 8'h22);
        expect_val("R9", 5, 8'h22);
        expect_val("R9", 7, 8'h11);
        wr(1'b0, 5'd19, 8'h33);
        expect_val("R9", 8, 8'h33);
        expect_val("R9", 6, 8'h00);
        // remap set
        wr(1'b1, 5'h18, 8'h20);
        wr(1'b0, 5'd18, 8'h44);
        expect_val("R8", 7, 8'h44);
        expect_val("R8", 5, 8'h44);
        wr(1'b0, 5'd19, 8'h55);
        expect_val("R8", 8, 8'h55);
        expect_val("R8", 6, 8'h55);
        wr(1'b0, 5'd3, 8'h66);
        expect_val("R9", 6, 8'h66);
        expect_val("R9", 8, 8'h55);
        rd("R8", 1'b0, 5'd2, 8'h44);
        // unimplemented indexes
        wr(1'b1, 5'h1F, 8'h77);
        expect_val("R1", 0, 8'h00);
        wr(1'b0, 5'd5, 8'h99);
        expect_val("R1", 0, 8'h00);
        expect_val("R1", 5, 8'h44);
        expect_val("R1", 1, 8'hA5);
        // data writes reuse the held index
        put_idx(1'b1, 5'h12);
        put_dat(8'h01);
        put_dat(8'h02);
        expect_val("R1", 1, 8'h02);
        // reset with strap low
        do_reset(1'b0);
        expect_val("R5", 3, 8'h03);
        rd("R5", 1'b1, 5'h16, 8'h80);
        expect_val("R2", 1, 8'h00);
        expect_val("R9", 6, 8'h00);
        repeat (2) @(posedge clk);
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule